// File: doc/BRIEF.md
# Converter Sample-Sequencer FIFO Bank

This block is the capture side of a data converter. It holds four sample sequencers. Each sequencer has a 16-entry circular result buffer, and a packed status word shows that buffer's pointers and flags. A trigger strobe, for example from a timer, places one synthetic sample into sequencer 0 when that sequencer is enabled, and it raises a raw interrupt. A linear congruential noise generator produces the sample in place of a real analog front end.

Software reaches the block through a simple synchronous register port. Each bus read of a sequencer's data window pops one result. Popping from an empty buffer and pushing into a full one are both recorded in sticky per-sequencer flag registers, and software clears those flags by writing ones. Sequencers 1 to 3 never receive samples, but their registers and buffers can still be addressed.

The bus is word-addressed by byte offset. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. A read access starts on the first cycle of a run of consecutive cycles with `bus_sel` high and `bus_wr` low. `bus_rdata` holds the value captured on that first cycle and keeps it until the next read access starts.

Top module: `conv_seq_fifo_bank`

## Requirements
- R1: After reset the status word of every sequencer reads 0x00000100 (empty). The mux, control, enable, raw interrupt, mask, overflow and underflow registers read 0, and `irq` is low.
- R2: A cycle with `trigger` high is accepted only when bit 0 of the enable register (offset 0x00) is set. An accepted trigger pushes one sample into buffer 0 and sets bit 0 of the raw interrupt register (offset 0x04). A trigger that is not accepted changes nothing.
- R3: The noise state is a 32-bit register that is zero at reset. Each accepted trigger updates it as state = state*314159 + 1, and the pushed sample is 0x200 plus bits 18:16 of the updated state. The state does not change when a trigger is not accepted.
- R4: Sequencer n has its registers at 0x40 + 0x20*n: mux at +0x00, control at +0x04, data pop at +0x08 and status at +0x0C. The status word holds the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12. A push stores the sample at the write pointer, advances that pointer modulo 16 and clears empty. Full is set when the push makes the two pointers equal, so 16 pushes into an empty buffer fill it.
- R5: A push into a full buffer stores nothing, sets bit n of the overflow register (offset 0x10) and leaves the buffer contents and pointers unchanged.
- R6: A read of the data window returns the entry at the read pointer as it stood before the read. The read then advances that pointer modulo 16, clears full, and sets empty when the two pointers become equal. This happens exactly once per read access, however many cycles the access is held.
- R7: A read of the data window of an empty buffer sets bit n of the underflow register (offset 0x18) and leaves both pointers and the flags unchanged.
- R8: The enable register keeps only bits 3:0 and the mask register (offset 0x08) keeps only bits 3:0. A mux register stores the written value AND 0x33333333. Control registers and the trigger-select register (offset 0x14) store all 32 bits.
- R9: Offset 0x0C reads as raw interrupt AND mask. Writing ones to offset 0x0C, 0x10 or 0x18 clears those bits of the raw interrupt, overflow or underflow register, and bits written as zero are kept.
- R10: `irq` is high exactly when raw interrupt AND mask is non-zero. It follows a change of either register one cycle after the edge that makes the change.
- R11: The buffers of sequencers 1 to 3 stay empty and addressable. A pop from one of them sets only its own underflow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | Sample strobe; each high cycle is one trigger |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data captured at the start of a read access |
| irq | output | 1 | Masked interrupt request |

## Verification
Writes, triggers and pops all update state at the clock edge where the bench presents them. Read data is captured at the first edge of a read access and holds after that. The bench drives every stimulus at a falling edge and samples one falling edge later, after exactly one rising edge, so each register-port result and the `irq` level are checked in the first cycle they are due. Held reads keep `bus_sel` high for several cycles, and the following status read then confirms that the pointer moved only once. Every expected value comes from a bench-side model of the buffers, the flags and the noise generator, which is updated as each stimulus is sent.

// File: rtl/conv_seq_fifo_bank.sv
module conv_seq_fifo_bank #(
  parameter int NSEQ  = 4,
  parameter int DEPTH = 16,
  parameter int SW    = 12,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trigger,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int PW      = $clog2(DEPTH);
  localparam int SIW     = $clog2(NSEQ);
  localparam int SEQ_LO  = 64;
  localparam int SEQ_HI  = SEQ_LO + 32 * NSEQ;
  localparam logic [31:0] LCG_MUL = 32'd314159;

  logic [NSEQ-1:0] act, ris, im, ovf, ufl;
  logic [31:0]     emux, lcg;
  logic [31:0]     muxr [NSEQ];
  logic [31:0]     ctlr [NSEQ];
  logic [31:0]     head [NSEQ];
  logic [31:0]     stat [NSEQ];
  logic [NSEQ-1:0] pop, push, fe, ff, ovf_set, ufl_set;
  logic [NSEQ-1:0][PW-1:0] rptr;
  logic            rd_hold;

  wire            rd_start = bus_sel & ~bus_wr & ~rd_hold;
  wire            wr_en    = bus_sel & bus_wr;
  wire            in_seq   = int'(bus_addr) >= SEQ_LO && int'(bus_addr) < SEQ_HI;
  wire [AW-1:0]   seq_off  = bus_addr - AW'(SEQ_LO);
  wire [SIW-1:0]  sidx     = seq_off[5 +: SIW];
  wire [4:0]      reg_off  = seq_off[4:0];
  wire            accept   = trigger & act[0];
  wire [31:0]     lcg_next = lcg * LCG_MUL + 32'd1;
  wire [SW-1:0]   sample   = SW'(32'h200 + {29'd0, lcg_next[18:16]});

  function automatic logic [NSEQ-1:0] clr_bits(input logic [AW-1:0] off);
    return (wr_en && bus_addr == off) ? bus_wdata[NSEQ-1:0] : '0;
  endfunction

  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    logic [SW-1:0] mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic          e, f;

    assign pop[g]  = rd_start & in_seq & (sidx == SIW'(g)) & (reg_off == 5'h08);
    assign push[g] = (g == 0) ? accept : 1'b0;

    wire pop_ok  = pop[g] & ~e;
    wire push_ok = push[g] & ~f;
    assign ovf_set[g] = push[g] & f;
    assign ufl_set[g] = pop[g] & e;

    always_ff @(posedge clk)
      if (push_ok) mem[wp] <= sample;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rp <= '0;
        wp <= '0;
        e  <= 1'b1;
        f  <= 1'b0;
      end else begin
        if (pop_ok)  rp <= rp + PW'(1);
        if (push_ok) wp <= wp + PW'(1);
        if (push_ok && !pop_ok) begin
          e <= 1'b0;
          f <= (wp + PW'(1)) == rp;
        end else if (pop_ok && !push_ok) begin
          f <= 1'b0;
          e <= (rp + PW'(1)) == wp;
        end
      end
    end

    assign fe[g]   = e;
    assign ff[g]   = f;
    assign rptr[g] = rp;
    assign head[g] = 32'(mem[rp]);
    assign stat[g] = 32'(rp) | (32'(wp) << 4) | (32'(e) << 8) | (32'(f) << 12);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= '0;
      ris     <= '0;
      im      <= '0;
      ovf     <= '0;
      ufl     <= '0;
      emux    <= '0;
      lcg     <= '0;
      rd_hold <= 1'b0;
      for (int i = 0; i < NSEQ; i++) begin
        muxr[i] <= '0;
        ctlr[i] <= '0;
      end
    end else begin
      rd_hold <= bus_sel & ~bus_wr;
      if (accept) lcg <= lcg_next;
      ris <= (ris & ~clr_bits(AW'(8'h0C))) | NSEQ'(accept);
      ovf <= (ovf & ~clr_bits(AW'(8'h10))) | ovf_set;
      ufl <= (ufl & ~clr_bits(AW'(8'h18))) | ufl_set;
      if (wr_en) begin
        if (in_seq) begin
          if (reg_off == 5'h00) muxr[sidx] <= bus_wdata & 32'h3333_3333;
          if (reg_off == 5'h04) ctlr[sidx] <= bus_wdata;
        end else begin
          if (bus_addr == AW'(8'h00)) act  <= bus_wdata[NSEQ-1:0];
          if (bus_addr == AW'(8'h08)) im   <= bus_wdata[NSEQ-1:0];
          if (bus_addr == AW'(8'h14)) emux <= bus_wdata;
        end
      end
    end
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (in_seq) begin
      case (reg_off)
        5'h00:   rd_val = muxr[sidx];
        5'h04:   rd_val = ctlr[sidx];
        5'h08:   rd_val = head[sidx];
        5'h0C:   rd_val = stat[sidx];
        default: rd_val = '0;
      endcase
    end else begin
      case (bus_addr)
        AW'(8'h00): rd_val = 32'(act);
        AW'(8'h04): rd_val = 32'(ris);
        AW'(8'h08): rd_val = 32'(im);
        AW'(8'h0C): rd_val = 32'(ris & im);
        AW'(8'h10): rd_val = 32'(ovf);
        AW'(8'h14): rd_val = emux;
        AW'(8'h18): rd_val = 32'(ufl);
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        bus_rdata <= '0;
    else if (rd_start) bus_rdata <= rd_val;
  end

  assign irq = |(ris & im);
endmodule

module conv_seq_fifo_bank_chk #(
  parameter int NSEQ = 4,
  parameter int PW   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    trigger,
  input logic [NSEQ-1:0]         act,
  input logic [NSEQ-1:0]         pop,
  input logic [NSEQ-1:0]         fe,
  input logic [NSEQ-1:0]         ff,
  input logic [NSEQ-1:0]         ovf,
  input logic [NSEQ-1:0]         ufl,
  input logic [NSEQ-1:0]         ris,
  input logic [NSEQ-1:0][PW-1:0] rptr,
  input logic                    irq
);
  assert_ris_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ris[0]) |-> $past(trigger & act[0]));

  assert_ovf_from_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf[0]) |-> $past(ff[0]));

  assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ff[0] && !pop[0] |=> ff[0]);

  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ris != '0));

  for (genvar n = 0; n < NSEQ; n++) begin : g_chk
    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(fe[n] && ff[n]));

    assert_ufl_from_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ufl[n]) |-> $past(fe[n]));

    assert_ptr_kept_on_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop[n] && fe[n] |=> $stable(rptr[n]));
  end
endmodule

bind conv_seq_fifo_bank conv_seq_fifo_bank_chk #(.NSEQ(NSEQ), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trigger(trigger), .act(act), .pop(pop),
  .fe(fe), .ff(ff), .ovf(ovf), .ufl(ufl), .ris(ris), .rptr(rptr), .irq(irq)
);

// File: tb/test_conv_seq_fifo_bank.sv
`timescale 1ns/1ps
module test_conv_seq_fifo_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trigger = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #2 clk = ~clk;

  conv_seq_fifo_bank i_conv_seq_fifo_bank (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_mem [4][16];
  logic [3:0]  m_rp [4];
  logic [3:0]  m_wp [4];
  bit          m_e [4];
  bit          m_f [4];
  logic [3:0]  m_act, m_ris, m_im, m_ovf, m_ufl;
  logic [31:0] m_lcg;

  function automatic logic [31:0] m_stat(input int n);
    return {19'd0, m_f[n], 3'd0, m_e[n], m_wp[n], m_rp[n]};
  endfunction

  function automatic void m_trigger();
    logic [31:0] s;
    if (!m_act[0]) return;
    m_lcg = m_lcg * 32'd314159 + 32'd1;
    s = 32'h200 + {29'd0, m_lcg[18:16]};
    m_ris[0] = 1'b1;
    if (m_f[0]) m_ovf[0] = 1'b1;
    else begin
      m_mem[0][m_wp[0]] = s;
      m_wp[0] = m_wp[0] + 4'd1;
      m_e[0] = 1'b0;
      m_f[0] = (m_wp[0] == m_rp[0]);
    end
  endfunction

  function automatic bit m_pop(input int n, output logic [31:0] v);
    v = '0;
    if (m_e[n]) begin
      m_ufl[n] = 1'b1;
      return 1'b0;
    end
    v = m_mem[n][m_rp[n]];
    m_rp[n] = m_rp[n] + 4'd1;
    m_f[n] = 1'b0;
    m_e[n] = (m_rp[n] == m_wp[n]);
    return 1'b1;
  endfunction

  task automatic chk(input logic [31:0] actual, input logic [31:0] expected, input string tag);
    tests++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, actual, expected);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int hold, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    repeat (hold) @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    m_trigger();
  endtask

  task automatic pop_chk(input int n, input int hold, input string tag);
    logic [31:0] d, exp;
    bit ok;
    ok = m_pop(n, exp);
    rd(8'h48 + 8'(n * 32), hold, d);
    if (ok) chk(d, exp, tag);
  endtask

  task automatic stat_chk(input int n, input string tag);
    logic [31:0] d;
    rd(8'h4C + 8'(n * 32), 1, d);
    chk(d, m_stat(n), tag);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int unsigned seed = 32'd12345;
    void'($urandom(seed));
    for (int n = 0; n < 4; n++) begin
      m_rp[n] = 0; m_wp[n] = 0; m_e[n] = 1; m_f[n] = 0;
    end
    m_act = 0; m_ris = 0; m_im = 0; m_ovf = 0; m_ufl = 0; m_lcg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int n = 0; n < 4; n++) begin
      stat_chk(n, "R1 reset status");
      rd(8'h40 + 8'(n * 32), 1, d); chk(d, 0, "R1 reset mux");
      rd(8'h44 + 8'(n * 32), 1, d); chk(d, 0, "R1 reset control");
    end
    rd(8'h00, 1, d); chk(d, 0, "R1 reset enable");
    rd(8'h10, 1, d); chk(d, 0, "R1 reset overflow");
    chk(32'(irq), 0, "R1 reset irq");

    pulse();
    stat_chk(0, "R2 trigger ignored when disabled");
    rd(8'h04, 1, d); chk(d, 0, "R2 raw int untouched when disabled");

    wr(8'h00, 32'hFFFF_FFFF); m_act = 4'hF;
    rd(8'h00, 1, d); chk(d, 32'hF, "R8 enable keeps 4 bits");
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, 1, d); chk(d, 32'h3333_3333, "R8 mux mask");
    wr(8'h84, 32'hDEAD_BEEF);
    rd(8'h84, 1, d); chk(d, 32'hDEAD_BEEF, "R8 control full width");
    wr(8'h14, 32'h1234_5678);
    rd(8'h14, 1, d); chk(d, 32'h1234_5678, "R8 trigger select");
    wr(8'h08, 32'hFFFF_FFF1); m_im = 4'h1;
    rd(8'h08, 1, d); chk(d, 32'h1, "R8 mask keeps 4 bits");

    pulse();
    chk(32'(irq), 1, "R10 irq on accepted trigger");
    rd(8'h04, 1, d); chk(d, 1, "R2 raw int set");
    rd(8'h0C, 1, d); chk(d, 1, "R9 masked status");
    wr(8'h0C, 32'h1); m_ris[0] = 0;
    chk(32'(irq), 0, "R10 irq drops after clear");
    rd(8'h04, 1, d); chk(d, 0, "R9 raw int cleared");
    wr(8'h08, 0); m_im = 0;
    pulse();
    chk(32'(irq), 0, "R10 irq masked");
    rd(8'h0C, 1, d); chk(d, 0, "R9 masked status zero when masked");

    for (int i = 0; i < 14; i++) pulse();
    stat_chk(0, "R4 full after 16 pushes");
    pulse();
    rd(8'h10, 1, d); chk(d, 32'(m_ovf), "R5 overflow bit 0");
    stat_chk(0, "R5 pointers unchanged on overflow");

    pop_chk(0, 4, "R6 held read value");
    stat_chk(0, "R6 one pop per held read");
    pulse();
    stat_chk(0, "R4 wrap push refills");
    for (int i = 0; i < 16; i++) pop_chk(0, 1, "R3 sample value");
    stat_chk(0, "R6 drained empty");
    pop_chk(0, 1, "R7 pop empty");
    rd(8'h18, 1, d); chk(d, 32'(m_ufl), "R7 underflow bit 0");
    stat_chk(0, "R7 pointers unchanged on underflow");
    wr(8'h10, 32'h1); m_ovf[0] = 0;
    rd(8'h10, 1, d); chk(d, 0, "R9 overflow cleared");
    wr(8'h18, 32'h0);
    rd(8'h18, 1, d); chk(d, 32'(m_ufl), "R9 zero write keeps underflow");
    wr(8'h18, 32'h1); m_ufl[0] = 0;

    pop_chk(2, 1, "R11 pop seq2");
    rd(8'h18, 1, d); chk(d, 32'h4, "R11 underflow bit 2 only");
    stat_chk(2, "R11 seq2 still empty");
    stat_chk(3, "R11 seq3 empty");
    wr(8'h18, 32'hF); m_ufl = 0;

    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom_range(0, 5));
      case (op)
        0, 1: pulse();
        2: pop_chk(0, int'($urandom_range(1, 3)), "R6 random pop");
        3: stat_chk(0, "R4 random status");
        4: begin
          rd(8'h10, 1, d); chk(d, 32'(m_ovf), "R5 random overflow");
          rd(8'h18, 1, d); chk(d, 32'(m_ufl), "R7 random underflow");
          rd(8'h04, 1, d); chk(d, 32'(m_ris), "R2 random raw int");
          wr(8'h10, 32'hF); m_ovf = 0;
          wr(8'h18, 32'hF); m_ufl = 0;
          wr(8'h0C, 32'hF); m_ris = 0;
        end
        default: begin
          logic [3:0] a = 4'($urandom_range(0, 15));
          wr(8'h00, 32'(a)); m_act = a;
        end
      endcase
    end
    finish_run();
  end
endmodule